// File: doc/BRIEF.md
# Armed Prioritized Interrupt Request Gate

This block holds the request state for a small group of interrupt sources and decides when the processor may be interrupted. Each source has a latched request flag, set by a hardware trigger pulse and cleared by software as its acknowledge. Each source also has an arm bit and a priority level. The processor side supplies a global disable bit and a priority threshold.

When at least one request passes every gate, the block raises a one-cycle take strobe. With the strobe it presents the winning source index and that source's vector address. The vector address is four times the interrupt number, and the interrupt number is the source index plus a fixed base. After a take, no further strobe is issued until the core signals end of service. A request whose flag software never clears is therefore offered again after every end of service.

Top module: `irq_gate`

## Requirements
- R1: After a synchronous reset, every request flag, arm bit and priority level is 0, `pending_o` is 0 and `take_o` is 0.
- R2: A 1 on `trig_i[k]` sets flag k, and `pending_o[k]` is 1 from the next clock on. The flag then stays set until a clear write (`clr_we_i`=1 with `clr_mask_i[k]`=1) removes it. Clear bits that are 0 leave their flags unchanged.
- R3: When a trigger and a clear of the same source fall in the same cycle, the flag ends up set.
- R4: A source is eligible only when all four of these hold: its flag is set, its arm bit is 1, `gdis_i` is 0, and either `thresh_i` is 0 or its priority level is numerically less than `thresh_i`. The block issues no take unless some source is eligible.
- R5: A flag that is set while some other gate is closed stays pending. It is taken once every gate is open: `take_o` rises on the clock edge after the last gate input or register opens.
- R6: When several sources are eligible, the one with the smallest priority value wins. If priorities are equal, the lowest source index wins.
- R7: `take_o` is high for exactly one cycle. No new take is issued until `eos_i` has been sampled high. A flag that is still set after that is taken again.
- R8: In the cycle where `take_o` is 1, `src_o` holds the winning index and `vec_o` equals 4*(BASE_NUM + `src_o`). With BASE_NUM=16, source 2 gives 0x48.
- R9: `arm_we_i` loads all arm bits from `arm_data_i`. `prio_we_i` writes `prio_data_i` into the level of source `prio_idx_i` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | N_SRC | Per-source hardware trigger pulses |
| clr_we_i | input | 1 | Software clear-write strobe |
| clr_mask_i | input | N_SRC | Write-one-to-clear mask for flags |
| arm_we_i | input | 1 | Arm register write strobe |
| arm_data_i | input | N_SRC | New arm bits |
| prio_we_i | input | 1 | Priority level write strobe |
| prio_idx_i | input | $clog2(N_SRC) | Source whose level is written |
| prio_data_i | input | PRIO_W | New priority level |
| gdis_i | input | 1 | Global interrupt disable (1 blocks all) |
| thresh_i | input | PRIO_W | Priority threshold, 0 means no masking |
| eos_i | input | 1 | End-of-service pulse from the core |
| pending_o | output | N_SRC | Current request flags |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| src_o | output | $clog2(N_SRC) | Winning source index |
| vec_o | output | VEC_W | Vector address of the winner |

## Verification
The main sweep runs every combination of flag pattern, arm pattern, disable bit and threshold on a four-source build. For each combination the four priority levels are rewritten from a formula, so ties, strict orderings and threshold edges all occur. The sweep separates requests that are blocked by a single closed gate from requests that pass. It also shows whether the winner follows priority first and index second, and whether the vector tracks the winner. Directed sequences cover the set-versus-clear collision, latching while unarmed followed by a later take, and re-request after end of service when the flag is not cleared. A final sequence checks that acknowledging the flag stops the requests.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_N_SRC    = 8;
  localparam int DEF_PRIO_W   = 3;
  localparam int DEF_BASE_NUM = 16;
  localparam int DEF_VEC_W    = 10;

  // Vector address: four bytes per table entry.
  function automatic int vec_of(input int base_num, input int idx);
    return (base_num + idx) * 4;
  endfunction
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N_SRC  = irq_pkg::DEF_N_SRC,
  parameter int PRIO_W = irq_pkg::DEF_PRIO_W,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              trig_i,
  input  logic                          clr_we_i,
  input  logic [N_SRC-1:0]              clr_mask_i,
  input  logic                          arm_we_i,
  input  logic [N_SRC-1:0]              arm_data_i,
  input  logic                          prio_we_i,
  input  logic [IDX_W-1:0]              prio_idx_i,
  input  logic [PRIO_W-1:0]             prio_data_i,
  output logic [N_SRC-1:0]              flag_q,
  output logic [N_SRC-1:0]              arm_q,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_q
);

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else if (arm_we_i) arm_q <= arm_data_i;
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic clr_hit;
    assign clr_hit = clr_we_i & clr_mask_i[k];

    // Trigger beats a same-cycle clear so no event is dropped.
    always_ff @(posedge clk) begin
      if (rst)             flag_q[k] <= 1'b0;
      else if (trig_i[k])  flag_q[k] <= 1'b1;
      else if (clr_hit)    flag_q[k] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) prio_q[k] <= '0;
      else if (prio_we_i && prio_idx_i == IDX_W'(k)) prio_q[k] <= prio_data_i;
    end

    a_r2_flag_sets: assert property (@(posedge clk) disable iff (rst)
      trig_i[k] |=> flag_q[k]);
    a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (trig_i[k] && clr_hit) |=> flag_q[k]);
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (flag_q[k] && !clr_hit) |=> flag_q[k]);
    a_r2_flag_no_spurious: assert property (@(posedge clk) disable iff (rst)
      (!flag_q[k] && !trig_i[k]) |=> !flag_q[k]);
  end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int N_SRC  = irq_pkg::DEF_N_SRC,
  parameter int PRIO_W = irq_pkg::DEF_PRIO_W
) (
  input  logic [N_SRC-1:0]             flag_i,
  input  logic [N_SRC-1:0]             arm_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thresh_i,
  output logic [N_SRC-1:0]             elig_o
);
  logic no_mask;
  assign no_mask = (thresh_i == '0);

  for (genvar k = 0; k < N_SRC; k++) begin : g_q
    assign elig_o[k] = flag_i[k] & arm_i[k] & (no_mask | (prio_i[k] < thresh_i));
  end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int N_SRC  = irq_pkg::DEF_N_SRC,
  parameter int PRIO_W = irq_pkg::DEF_PRIO_W,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_SRC-1:0]             elig_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             win_o
);
  logic [PRIO_W-1:0] best_p;

  // Strict compare keeps the earlier (lower) index on a tie.
  always_comb begin
    valid_o = 1'b0;
    win_o   = '0;
    best_p  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] < best_p)) begin
        valid_o = 1'b1;
        win_o   = IDX_W'(i);
        best_p  = prio_i[i];
      end
    end
  end

  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> elig_i[win_o]);

  for (genvar k = 0; k < N_SRC; k++) begin : g_chk
    a_r6_no_better: assert property (@(posedge clk) disable iff (rst)
      (valid_o && elig_i[k]) |->
        (prio_i[k] > prio_i[win_o]) ||
        (prio_i[k] == prio_i[win_o] && IDX_W'(k) >= win_o));
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_SRC    = irq_pkg::DEF_N_SRC,
  parameter int PRIO_W   = irq_pkg::DEF_PRIO_W,
  parameter int BASE_NUM = irq_pkg::DEF_BASE_NUM,
  parameter int VEC_W    = irq_pkg::DEF_VEC_W,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  trig_i,
  input  logic              clr_we_i,
  input  logic [N_SRC-1:0]  clr_mask_i,
  input  logic              arm_we_i,
  input  logic [N_SRC-1:0]  arm_data_i,
  input  logic              prio_we_i,
  input  logic [IDX_W-1:0]  prio_idx_i,
  input  logic [PRIO_W-1:0] prio_data_i,
  input  logic              gdis_i,
  input  logic [PRIO_W-1:0] thresh_i,
  input  logic              eos_i,
  output logic [N_SRC-1:0]  pending_o,
  output logic              take_o,
  output logic [IDX_W-1:0]  src_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_SRC-1:0]             flag_q, arm_q, elig;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic                         win_valid, take_now, in_svc_q;
  logic [IDX_W-1:0]             win;

  irq_src_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst(rst), .trig_i(trig_i), .clr_we_i(clr_we_i),
    .clr_mask_i(clr_mask_i), .arm_we_i(arm_we_i), .arm_data_i(arm_data_i),
    .prio_we_i(prio_we_i), .prio_idx_i(prio_idx_i), .prio_data_i(prio_data_i),
    .flag_q(flag_q), .arm_q(arm_q), .prio_q(prio_q)
  );

  irq_qualify #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_qual (
    .flag_i(flag_q), .arm_i(arm_q), .prio_i(prio_q),
    .thresh_i(thresh_i), .elig_o(elig)
  );

  irq_select #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_sel (
    .clk(clk), .rst(rst), .elig_i(elig), .prio_i(prio_q),
    .valid_o(win_valid), .win_o(win)
  );

  assign take_now  = win_valid & ~gdis_i & ~in_svc_q;
  assign pending_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst)           in_svc_q <= 1'b0;
    else if (take_now) in_svc_q <= 1'b1;
    else if (eos_i)    in_svc_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      src_o  <= '0;
      vec_o  <= '0;
    end else begin
      take_o <= take_now;
      if (take_now) begin
        src_o <= win;
        vec_o <= VEC_W'(irq_pkg::vec_of(BASE_NUM, int'(win)));
      end
    end
  end

  a_r4_take_gated: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(!gdis_i && !in_svc_q));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
  a_r7_hold_until_eos: assert property (@(posedge clk) disable iff (rst)
    (in_svc_q && !eos_i) |=> !take_o);
  a_r4_take_needs_flag: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(flag_q[win]));
endmodule

// File: tb/tb_irq_gate.sv
module tb_irq_gate;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int BASE = 16;
  localparam int VW = 8;

  logic clk = 0, rst = 1;
  logic [N-1:0] trig = 0, clr_mask = 0, arm_data = 0;
  logic clr_we = 0, arm_we = 0, prio_we = 0, gdis = 1, eos = 0;
  logic [1:0] prio_idx = 0;
  logic [PW-1:0] prio_data = 0, thresh = 0;
  logic [N-1:0] pending;
  logic take;
  logic [1:0] src;
  logic [VW-1:0] vec;

  int checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  irq_gate #(.N_SRC(N), .PRIO_W(PW), .BASE_NUM(BASE), .VEC_W(VW)) dut (
    .clk(clk), .rst(rst), .trig_i(trig), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .arm_we_i(arm_we), .arm_data_i(arm_data), .prio_we_i(prio_we),
    .prio_idx_i(prio_idx), .prio_data_i(prio_data), .gdis_i(gdis),
    .thresh_i(thresh), .eos_i(eos), .pending_o(pending), .take_o(take),
    .src_o(src), .vec_o(vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p[N];
    bit el[N];
    int win, bestp;
    bit any;
    tick(); tick();
    // R1 reset state
    chk(pending == 0, "R1 pending", pending, 0);
    chk(take == 0, "R1 take", take, 0);
    rst = 0;
    tick();
    chk(pending == 0 && take == 0, "R1 after release", pending, 0);

    // Sweep: flags x arm x disable x threshold, levels varied per case
    for (int c = 0; c < 2048; c++) begin
      logic [3:0] fm, am;
      bit gd;
      logic [1:0] th;
      fm = c[3:0]; am = c[7:4]; gd = c[8]; th = c[10:9];
      gdis = 1; clr_we = 1; clr_mask = '1; eos = 1;
      tick();
      clr_we = 0; eos = 0; arm_we = 1; arm_data = am; thresh = th;
      tick();
      arm_we = 0;
      for (int k = 0; k < N; k++) begin
        p[k] = (c + 3 * k + (c >> 4) + (k * c >> 2)) % 4;
        prio_we = 1; prio_idx = 2'(k); prio_data = 2'(p[k]);
        tick();
      end
      prio_we = 0; trig = fm;
      tick();
      trig = 0;
      tick();
      chk(pending == fm, "R2 flags latched", pending, fm);
      chk(take == 0, "R4 disabled no take", take, 0);
      any = 0; win = 0; bestp = 0;
      for (int k = 0; k < N; k++) begin
        el[k] = fm[k] && am[k] && (th == 0 || p[k] < th);
        if (el[k] && (!any || p[k] < bestp)) begin
          any = 1; win = k; bestp = p[k];
        end
      end
      gdis = gd;
      tick();
      chk(take == (any && !gd), "R4 take gating", take, any && !gd);
      if (any && !gd) begin
        chk(src == 2'(win), "R6 winner", src, win);
        chk(vec == 8'((BASE + win) * 4), "R8 vector", vec, (BASE + win) * 4);
      end
      tick();
      chk(take == 0, "R7 single cycle", take, 0);
      chk(pending == fm, "R5 flags stay pending", pending, fm);
    end

    // R8 example: source 2 -> 0x48; R3 collision
    gdis = 1; clr_we = 1; clr_mask = '1; eos = 1;
    tick();
    clr_we = 0; eos = 0; arm_we = 1; arm_data = '1; thresh = 0;
    tick();
    arm_we = 0; trig = 4'b0100;
    tick();
    trig = 4'b0010; clr_we = 1; clr_mask = 4'b0010;
    tick();
    trig = 0; clr_we = 0;
    tick();
    chk(pending[1] == 1, "R3 set wins over clear", pending[1], 1);
    clr_we = 1; clr_mask = 4'b0010;
    tick();
    clr_we = 0;
    tick();
    chk(pending == 4'b0100, "R2 clear one flag", pending, 4);
    gdis = 0;
    tick();
    chk(take == 1 && src == 2, "R8 source 2 taken", src, 2);
    chk(vec == 8'h48, "R8 vector 0x48", vec, 'h48);
    // R7 no retake without eos
    tick(); tick(); tick();
    chk(take == 0, "R7 blocked in service", take, 0);
    eos = 1;
    tick();
    eos = 0;
    chk(take == 0, "R7 eos edge", take, 0);
    tick();
    chk(take == 1 && src == 2, "R7 re-request uncleared", take, 1);
    // ack then eos: no further take
    clr_we = 1; clr_mask = 4'b0100; eos = 1;
    tick();
    clr_we = 0; eos = 0;
    tick(); tick();
    chk(take == 0 && pending == 0, "R2 ack stops requests", pending, 0);

    // R5 latched while unarmed, then armed; R9 arm load
    arm_we = 1; arm_data = 0;
    tick();
    arm_we = 0; trig = 4'b1000;
    tick();
    trig = 0;
    tick(); tick();
    chk(take == 0 && pending == 4'b1000, "R5 unarmed pending", pending, 8);
    arm_we = 1; arm_data = 4'b1000;
    tick();
    arm_we = 0;
    chk(take == 0, "R9 arm write latency", take, 0);
    tick();
    chk(take == 1 && src == 3, "R5 taken once armed", src, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule